// File: doc/BRIEF.md
# Eight-Pin GPIO Port with Peripheral Direction Override

This block is an eight-pin general-purpose I/O port. It has two registers on a small register bus. The direction register can be read and written at any time. Each set bit makes its pin an output, which then drives the general-purpose output value supplied to the block. The status register is read-only and returns the pins as seen through a two-flop synchronizer. It does this even for pins the port is driving, so software can compare what it drives against what the pin actually carries and spot an overloaded or shorted output.

Three on-chip peripherals can take over selected pins:
- A CAN-style transceiver interface owns a transmit pin and a receive pin.
- A two-wire serial controller owns a clock pin and a data pin. It drives them open-drain.
- A UART owns its transmit pin while its transmitter is on, and its receive pin while its receiver is on.

A takeover never alters the stored direction bits. When the peripheral lets go, the register bits control the pin again. If two peripherals are mapped onto the same pin, CAN wins over the two-wire controller, and the two-wire controller wins over the UART. Pin 3 does not exist in this port: its bits read zero and ignore writes.

Top module: `gpio_ovr_port`

## Requirements
- R1: During and right after a synchronous reset, the direction register reads 0x00, the status register reads 0x00 and no pin output enable is set.
- R2: A write with bus_sel=0 stores bus_wdata into the direction register, and a read with bus_sel=0 returns it. Bit 3 always reads 0 and is not stored.
- R3: With no peripheral enabled, pin_oe equals the direction register, and a pin whose direction bit is 1 drives the matching bit of gpio_dout on pin_out.
- R4: A read with bus_sel=1 returns pin_in as it was two clock edges earlier, with bit 3 forced to 0. This holds for pins being driven as outputs. The first real pin values appear two clock edges after reset is released.
- R5: A write with bus_sel=1 (the status register) changes neither the direction register nor the status register contents.
- R6: While can_en=1, pin CAN_TX_PIN (default 7) is an output driving can_tx, and pin CAN_RX_PIN (default 6) is an input.
- R7: While uart_en=1, pin UART_TX_PIN (default 1) is an output driving uart_tx when uart_tx_en=1, and pin UART_RX_PIN (default 0) is an input when uart_rx_en=1. A UART pin whose function is off follows the direction register.
- R8: While twi_en=1, pins TWI_SCL_PIN (default 5) and TWI_SDA_PIN (default 4) drive pin_out=0. Their output enables follow twi_scl_low and twi_sda_low (open-drain).
- R9: A peripheral override never changes the stored direction bits. After the peripheral is disabled, its pins follow the direction register again.
- R10: On a pin claimed by several enabled peripherals, CAN wins over the two-wire controller, and the two-wire controller wins over the UART.
- R11: bus_rdata is 0x00 whenever bus_rd is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register select: 0 direction, 1 pin status |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle of bus_rd |
| gpio_dout | input | 8 | General-purpose output values |
| pin_in | input | 8 | Pin levels from the pads |
| pin_oe | output | 8 | Per-pin output enable |
| pin_out | output | 8 | Per-pin output value |
| can_en | input | 1 | CAN function enable |
| can_tx | input | 1 | CAN transmit value |
| twi_en | input | 1 | Two-wire controller enable |
| twi_scl_low | input | 1 | Request to pull the clock pin low |
| twi_sda_low | input | 1 | Request to pull the data pin low |
| uart_en | input | 1 | UART function enable |
| uart_tx_en | input | 1 | UART transmitter enable |
| uart_rx_en | input | 1 | UART receiver enable |
| uart_tx | input | 1 | UART transmit value |

## Verification
The assertions check these behaviours on every cycle:
- The status register trails the pins by two edges once two cycles have passed since reset.
- The direction bits move only on a direction-register write, so neither a status-register write nor any peripheral takeover disturbs them.
- The CAN pins take the directions they are forced to.
- pin_oe mirrors the direction register when no peripheral is enabled.
- Read data stays zero when no read is in progress.

Other behaviours can only be shown by the bench's scenarios:
- The exact cycle after reset release at which the first pin values appear.
- Bit 3 being dropped on write.
- The UART and open-drain two-wire pin behaviour.
- Control returning to the register bits after a peripheral is disabled.
- Priority on a pin shared by several peripherals. This needs a second instance with overlapping pin parameters.

// File: rtl/gpio_ovr_pkg.sv
package gpio_ovr_pkg;

    localparam int PORT_W = 8;

    typedef enum logic [1:0] {
        OWN_REG  = 2'd0,
        OWN_CAN  = 2'd1,
        OWN_TWI  = 2'd2,
        OWN_UART = 2'd3
    } pin_owner_e;

    typedef struct packed {
        logic oe;
        logic val;
    } pin_drive_t;

    // Fixed arbitration among peripherals claiming one pin
    function automatic pin_owner_e pick_owner(input logic can_c,
                                              input logic twi_c,
                                              input logic uart_c);
        if (can_c)       return OWN_CAN;
        else if (twi_c)  return OWN_TWI;
        else if (uart_c) return OWN_UART;
        else             return OWN_REG;
    endfunction

endpackage

// File: rtl/gpio_ovr_dirreg.sv
module gpio_ovr_dirreg #(
    parameter int          W    = 8,
    parameter logic [W-1:0] MASK = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)        q <= '0;
        else if (wr_en) q <= wdata & MASK;
    end
endmodule

// File: rtl/gpio_ovr_insync.sv
module gpio_ovr_insync #(
    parameter int          W    = 8,
    parameter logic [W-1:0] MASK = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;
    logic [W-1:0] stage2;

    for (genvar b = 0; b < W; b++) begin : g_bit
        if (MASK[b]) begin : g_live
            always_ff @(posedge clk) begin
                if (rst) begin
                    stage1[b] <= 1'b0;
                    stage2[b] <= 1'b0;
                end else begin
                    stage1[b] <= d[b];
                    stage2[b] <= stage1[b];
                end
            end
        end else begin : g_dead
            assign stage1[b] = 1'b0;
            assign stage2[b] = 1'b0;
        end
    end

    assign q = stage2;
endmodule

// File: rtl/gpio_ovr_pinmux.sv
module gpio_ovr_pinmux
    import gpio_ovr_pkg::*;
#(
    parameter int W           = 8,
    parameter int CAN_TX_PIN  = 7,
    parameter int CAN_RX_PIN  = 6,
    parameter int TWI_SCL_PIN = 5,
    parameter int TWI_SDA_PIN = 4,
    parameter int UART_TX_PIN = 1,
    parameter int UART_RX_PIN = 0
) (
    input  logic [W-1:0] dir,
    input  logic [W-1:0] gp_out,
    input  logic         can_en,
    input  logic         can_tx,
    input  logic         twi_en,
    input  logic         twi_scl_low,
    input  logic         twi_sda_low,
    input  logic         uart_en,
    input  logic         uart_tx_en,
    input  logic         uart_rx_en,
    input  logic         uart_tx,
    output logic [W-1:0] oe,
    output logic [W-1:0] out
);
    for (genvar p = 0; p < W; p++) begin : g_pin
        localparam bit IS_CAN_TX  = (p == CAN_TX_PIN);
        localparam bit IS_CAN_RX  = (p == CAN_RX_PIN);
        localparam bit IS_SCL     = (p == TWI_SCL_PIN);
        localparam bit IS_SDA     = (p == TWI_SDA_PIN);
        localparam bit IS_UART_TX = (p == UART_TX_PIN);
        localparam bit IS_UART_RX = (p == UART_RX_PIN);

        logic       can_claim, twi_claim, uart_claim;
        pin_owner_e owner;
        pin_drive_t drv;

        always_comb begin
            can_claim  = can_en && (IS_CAN_TX || IS_CAN_RX);
            twi_claim  = twi_en && (IS_SCL || IS_SDA);
            uart_claim = uart_en && ((uart_tx_en && IS_UART_TX) ||
                                     (uart_rx_en && IS_UART_RX));
            owner = pick_owner(can_claim, twi_claim, uart_claim);

            case (owner)
                OWN_CAN: begin
                    drv.oe  = IS_CAN_TX;
                    drv.val = IS_CAN_TX ? can_tx : 1'b0;
                end
                OWN_TWI: begin
                    drv.oe  = IS_SCL ? twi_scl_low : twi_sda_low;
                    drv.val = 1'b0;
                end
                OWN_UART: begin
                    drv.oe  = uart_tx_en && IS_UART_TX;
                    drv.val = (uart_tx_en && IS_UART_TX) ? uart_tx : 1'b0;
                end
                default: begin
                    drv.oe  = dir[p];
                    drv.val = dir[p] ? gp_out[p] : 1'b0;
                end
            endcase
        end

        assign oe[p]  = drv.oe;
        assign out[p] = drv.val;
    end
endmodule

// File: rtl/gpio_ovr_port.sv
module gpio_ovr_port
    import gpio_ovr_pkg::*;
#(
    parameter int                W           = PORT_W,
    parameter logic [PORT_W-1:0] IMPL_MASK   = 8'hF7,
    parameter int                CAN_TX_PIN  = 7,
    parameter int                CAN_RX_PIN  = 6,
    parameter int                TWI_SCL_PIN = 5,
    parameter int                TWI_SDA_PIN = 4,
    parameter int                UART_TX_PIN = 1,
    parameter int                UART_RX_PIN = 0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         bus_sel,
    input  logic         bus_rd,
    input  logic         bus_wr,
    input  logic [W-1:0] bus_wdata,
    output logic [W-1:0] bus_rdata,
    input  logic [W-1:0] gpio_dout,
    input  logic [W-1:0] pin_in,
    output logic [W-1:0] pin_oe,
    output logic [W-1:0] pin_out,
    input  logic         can_en,
    input  logic         can_tx,
    input  logic         twi_en,
    input  logic         twi_scl_low,
    input  logic         twi_sda_low,
    input  logic         uart_en,
    input  logic         uart_tx_en,
    input  logic         uart_rx_en,
    input  logic         uart_tx
);
    localparam logic SEL_DIR  = 1'b0;
    localparam logic SEL_STAT = 1'b1;

    logic [W-1:0] dir_q;
    logic [W-1:0] in_q;
    logic         dir_wr;

    assign dir_wr = bus_wr && (bus_sel == SEL_DIR);

    gpio_ovr_dirreg #(.W(W), .MASK(IMPL_MASK)) u_dir (
        .clk   (clk),
        .rst   (rst),
        .wr_en (dir_wr),
        .wdata (bus_wdata),
        .q     (dir_q)
    );

    gpio_ovr_insync #(.W(W), .MASK(IMPL_MASK)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_in),
        .q   (in_q)
    );

    gpio_ovr_pinmux #(
        .W(W), .CAN_TX_PIN(CAN_TX_PIN), .CAN_RX_PIN(CAN_RX_PIN),
        .TWI_SCL_PIN(TWI_SCL_PIN), .TWI_SDA_PIN(TWI_SDA_PIN),
        .UART_TX_PIN(UART_TX_PIN), .UART_RX_PIN(UART_RX_PIN)
    ) u_mux (
        .dir         (dir_q),
        .gp_out      (gpio_dout),
        .can_en      (can_en),
        .can_tx      (can_tx),
        .twi_en      (twi_en),
        .twi_scl_low (twi_scl_low),
        .twi_sda_low (twi_sda_low),
        .uart_en     (uart_en),
        .uart_tx_en  (uart_tx_en),
        .uart_rx_en  (uart_rx_en),
        .uart_tx     (uart_tx),
        .oe          (pin_oe),
        .out         (pin_out)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) bus_rdata = (bus_sel == SEL_STAT) ? in_q : dir_q;
    end
endmodule

// File: rtl/gpio_ovr_chk.sv
module gpio_ovr_chk #(
    parameter int          W          = 8,
    parameter logic [W-1:0] MASK      = '1,
    parameter int          CAN_TX_PIN = 7,
    parameter int          CAN_RX_PIN = 6
) (
    input logic         clk,
    input logic         rst,
    input logic         bus_sel,
    input logic         bus_rd,
    input logic         bus_wr,
    input logic [W-1:0] bus_rdata,
    input logic [W-1:0] pin_in,
    input logic [W-1:0] pin_oe,
    input logic         can_en,
    input logic         twi_en,
    input logic         uart_en,
    input logic [W-1:0] dir_q,
    input logic [W-1:0] in_q
);
    logic [1:0] since_rst;
    always_ff @(posedge clk) begin
        if (rst)                 since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    AST_STATUS_LAG: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 2'd2) |-> (in_q == ($past(pin_in, 2) & MASK))); // R4
    AST_STATUS_WR_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_sel) |=> $stable(dir_q)); // R5
    AST_DIR_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (rst)
        !(bus_wr && !bus_sel) |=> $stable(dir_q)); // R9
    AST_CAN_DIRS: assert property (@(posedge clk) disable iff (rst)
        can_en |-> (pin_oe[CAN_TX_PIN] && !pin_oe[CAN_RX_PIN])); // R6
    AST_REG_OWNS_OE: assert property (@(posedge clk) disable iff (rst)
        (!can_en && !twi_en && !uart_en) |-> (pin_oe == dir_q)); // R3
    AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |-> (bus_rdata == '0)); // R11
endmodule

bind gpio_ovr_port gpio_ovr_chk #(
    .W(W), .MASK(IMPL_MASK), .CAN_TX_PIN(CAN_TX_PIN), .CAN_RX_PIN(CAN_RX_PIN)
) u_chk (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_rdata(bus_rdata), .pin_in(pin_in), .pin_oe(pin_oe), .can_en(can_en),
    .twi_en(twi_en), .uart_en(uart_en), .dir_q(dir_q), .in_q(in_q)
);

// File: tb/tb_gpio_ovr_port.sv
`timescale 1ns/1ps
module tb_gpio_ovr_port;
    logic       clk = 1'b0;
    logic       rst;
    logic       bus_sel, bus_rd, bus_wr;
    logic [7:0] bus_wdata, bus_rdata, rdata_ovl;
    logic [7:0] gpio_dout, pin_in;
    logic [7:0] pin_oe, pin_out, oe_ovl, out_ovl;
    logic       can_en, can_tx, twi_en, twi_scl_low, twi_sda_low;
    logic       uart_en, uart_tx_en, uart_rx_en, uart_tx;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    gpio_ovr_port dut (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .gpio_dout(gpio_dout),
        .pin_in(pin_in), .pin_oe(pin_oe), .pin_out(pin_out),
        .can_en(can_en), .can_tx(can_tx), .twi_en(twi_en),
        .twi_scl_low(twi_scl_low), .twi_sda_low(twi_sda_low),
        .uart_en(uart_en), .uart_tx_en(uart_tx_en), .uart_rx_en(uart_rx_en),
        .uart_tx(uart_tx)
    );

    // Second instance: pin 7 shared by CAN tx, two-wire clock and UART tx
    gpio_ovr_port #(.TWI_SCL_PIN(7), .UART_TX_PIN(7)) dut_ovl (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(rdata_ovl), .gpio_dout(gpio_dout),
        .pin_in(pin_in), .pin_oe(oe_ovl), .pin_out(out_ovl),
        .can_en(can_en), .can_tx(can_tx), .twi_en(twi_en),
        .twi_scl_low(twi_scl_low), .twi_sda_low(twi_sda_low),
        .uart_en(uart_en), .uart_tx_en(uart_tx_en), .uart_rx_en(uart_rx_en),
        .uart_tx(uart_tx)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [7:0] d);
        @(negedge clk);
        bus_sel = sel; bus_wr = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic sel, output logic [7:0] d);
        @(negedge clk);
        bus_sel = sel; bus_rd = 1'b1;
        #1 d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic clear_periph();
        can_en = 0; can_tx = 0; twi_en = 0; twi_scl_low = 0; twi_sda_low = 0;
        uart_en = 0; uart_tx_en = 0; uart_rx_en = 0; uart_tx = 0;
    endtask

    // R1 and R4: reset values and status start-up delay
    task automatic t_reset();
        logic [7:0] d;
        pin_in = 8'hFF;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 dir during reset", dut.bus_rdata, 8'h00);
        bus_sel = 1'b1; bus_rd = 1'b1; #1;
        chk("R1 status during reset", bus_rdata, 8'h00);
        bus_rd = 1'b0;
        chk("R1 oe during reset", pin_oe, 8'h00);
        rst = 1'b0;
        @(posedge clk); @(negedge clk);
        bus_sel = 1'b1; bus_rd = 1'b1; #1;
        chk("R4 status one edge after release", bus_rdata, 8'h00);
        bus_rd = 1'b0;
        @(posedge clk); @(negedge clk);
        bus_sel = 1'b1; bus_rd = 1'b1; #1;
        chk("R4 status two edges after release", bus_rdata, 8'hF7);
        bus_rd = 1'b0;
        rd(1'b0, d);
        chk("R1 dir after reset", d, 8'h00);
    endtask

    // R2: direction read/write, bit 3 dropped
    task automatic t_dir_rw();
        logic [7:0] d;
        wr(1'b0, 8'hFF); rd(1'b0, d);
        chk("R2 dir all ones", d, 8'hF7);
        wr(1'b0, 8'h5A); rd(1'b0, d);
        chk("R2 dir 5A", d, 8'h52);
        wr(1'b0, 8'h08); rd(1'b0, d);
        chk("R2 bit3 only", d, 8'h00);
    endtask

    // R3: register-controlled drive
    task automatic t_reg_drive();
        wr(1'b0, 8'hC3);
        gpio_dout = 8'hA5; #1;
        chk("R3 oe", pin_oe, 8'hC3);
        chk("R3 out", pin_out, 8'h81);
        gpio_dout = 8'h5A; #1;
        chk("R3 out toggled", pin_out, 8'h42);
    endtask

    // R4: status lag and readback of driven pins
    task automatic t_status();
        logic [7:0] d;
        @(negedge clk); pin_in = 8'h3C;
        @(posedge clk); @(negedge clk);
        bus_sel = 1'b1; bus_rd = 1'b1; #1;
        chk("R4 status not yet", bus_rdata, 8'hF7);
        bus_rd = 1'b0;
        @(posedge clk);
        rd(1'b1, d);
        chk("R4 status updated", d, 8'h34);
        @(negedge clk); pin_in = 8'h01;
        repeat (3) @(posedge clk);
        rd(1'b1, d);
        chk("R4 driven pins visible", d, 8'h01);
    endtask

    // R5: writes to status address ignored
    task automatic t_ro_write();
        logic [7:0] d;
        wr(1'b0, 8'h11);
        wr(1'b1, 8'hEE);
        rd(1'b0, d);
        chk("R5 dir unchanged", d, 8'h11);
        rd(1'b1, d);
        chk("R5 status unchanged", d, 8'h01);
    endtask

    // R6 and R9: CAN override keeps direction bits
    task automatic t_can();
        logic [7:0] d;
        wr(1'b0, 8'h40);
        can_en = 1; can_tx = 1; #1;
        chk("R6 can oe", pin_oe & 8'hC0, 8'h80);
        chk("R6 can out", pin_out & 8'hC0, 8'h80);
        can_tx = 0; #1;
        chk("R6 can tx low", pin_out & 8'h80, 8'h00);
        rd(1'b0, d);
        chk("R9 dir kept under can", d, 8'h40);
        can_en = 0; #1;
        chk("R9 dir back after can", pin_oe, 8'h40);
    endtask

    // R7: UART per-direction takeover
    task automatic t_uart();
        wr(1'b0, 8'h01);
        uart_en = 1; uart_tx_en = 1; uart_tx = 1; #1;
        chk("R7 tx only", pin_oe & 8'h03, 8'h03);
        chk("R7 tx value", pin_out & 8'h02, 8'h02);
        uart_rx_en = 1; #1;
        chk("R7 rx input", pin_oe & 8'h03, 8'h02);
        uart_tx_en = 0; #1;
        chk("R7 tx released", pin_oe & 8'h03, 8'h00);
        clear_periph(); #1;
        chk("R9 after uart", pin_oe, 8'h01);
    endtask

    // R8: two-wire open-drain
    task automatic t_twi();
        logic [7:0] d;
        wr(1'b0, 8'h30);
        gpio_dout = 8'hFF;
        twi_en = 1; twi_scl_low = 1; twi_sda_low = 0; #1;
        chk("R8 oe", pin_oe & 8'h30, 8'h20);
        chk("R8 out", pin_out & 8'h30, 8'h00);
        twi_scl_low = 0; twi_sda_low = 1; #1;
        chk("R8 oe swap", pin_oe & 8'h30, 8'h10);
        rd(1'b0, d);
        chk("R9 dir kept under twi", d, 8'h30);
        clear_periph(); #1;
        chk("R9 after twi", pin_out & 8'h30, 8'h30);
    endtask

    // R10: priority on shared pin 7 (dut_ovl)
    task automatic t_priority();
        wr(1'b0, 8'h00);
        can_en = 1; can_tx = 1; twi_en = 1; twi_scl_low = 0;
        uart_en = 1; uart_tx_en = 1; uart_tx = 0; #1;
        chk("R10 can wins", {oe_ovl[7], out_ovl[7]}, 8'h03);
        can_en = 0; #1;
        chk("R10 twi over uart", {oe_ovl[7], out_ovl[7]}, 8'h00);
        twi_en = 0; uart_tx = 1; #1;
        chk("R10 uart alone", {oe_ovl[7], out_ovl[7]}, 8'h03);
        clear_periph();
    endtask

    // R11: idle read data
    task automatic t_idle();
        wr(1'b0, 8'hF7);
        @(negedge clk); bus_rd = 1'b0; bus_sel = 1'b0; #1;
        chk("R11 idle rdata dir", bus_rdata, 8'h00);
        bus_sel = 1'b1; #1;
        chk("R11 idle rdata status", bus_rdata, 8'h00);
    endtask

    initial begin
        bus_sel = 0; bus_rd = 0; bus_wr = 0; bus_wdata = 0;
        gpio_dout = 0; pin_in = 0; rst = 1;
        clear_periph();
        t_reset();
        t_dir_rw();
        t_reg_drive();
        t_status();
        t_ro_write();
        t_can();
        t_uart();
        t_twi();
        t_priority();
        t_idle();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule